// File: doc/BRIEF.md
# Quadratic Polynomial Evaluator with Enable

This block computes a second-order polynomial of an unsigned operand entirely in combinational logic. The three coefficients are fixed when the block is elaborated. Because they are constants, each product reduces to a multiply by a known value, which synthesis can shrink to a few shifted adds. Only the operand squarer remains a general multiplier.

The result port is sized from the operand and coefficient widths so that the largest possible result fits. An enable input gates the result: when enable is deasserted the port reads zero for any operand. Coefficient values outside the range allowed by the coefficient width stop elaboration with an error.

Top module: `quad_poly_eval`

## Requirements
- R1: With `enable` = 1, `y_out` equals K0 + K1*x + K2*x*x for every operand value x from 0 to 255, where K0, K1 and K2 are the constant-, linear- and square-term coefficients.
- R2: With `enable` = 0, `y_out` is 0 for every operand value.
- R3: With default widths, `y_out` is 24 bits wide. With all three coefficients at 255 and x = 255, it reads 16646655 with no truncation.
- R4: The block holds no state. `y_out` follows a change on `x_in` or `enable` with no clock edge in between.
- R5: With `enable` = 1 and x = 0, `y_out` equals the constant-term coefficient alone.
- R6: A coefficient set to 0 removes its term. With the linear coefficient at 0, `y_out` equals K0 + K2*x*x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enable | input | 1 | Result gate; 0 forces the output to zero |
| x_in | input | XW (8) | Unsigned operand |
| y_out | output | RW (24) | Unsigned polynomial value, zero-extended |

## Verification
Three instances with different coefficient sets are swept over all 256 operands, first with enable high and then with it low. The enable-high sweep shows whether the sum of terms is correct. The enable-low sweep shows whether the gate suppresses every bit of the result. The set with all coefficients at 255 reaches the top of the output range, so a result port that is too narrow or a dropped carry shows up in the upper bits. The set with a zero linear coefficient separates a wrong linear term from a wrong square term. Finally, two operand changes within one half clock period show that the output settles with no register on the path.

// File: rtl/poly_pkg.sv
package poly_pkg;

  // Bits needed for cmax * (1 + xmax + xmax^2), the worst-case result.
  function automatic int result_width(int xw, int cw);
    longint xm;
    longint cm;
    longint mx;
    int     w;
    xm = (longint'(1) << xw) - 1;
    cm = (longint'(1) << cw) - 1;
    mx = cm * (1 + xm + xm * xm);
    w  = 0;
    while (mx > 0) begin
      w++;
      mx = mx >> 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/poly_square.sv
module poly_square #(
  parameter int XW = 8,
  localparam int SQW = 2 * XW
) (
  input  logic [XW-1:0]  op_i,
  output logic [SQW-1:0] sq_o
);

  always_comb begin
    sq_o = SQW'(op_i) * SQW'(op_i);
  end

endmodule

// File: rtl/poly_scale.sv
module poly_scale #(
  parameter int          IW   = 8,
  parameter int          OW   = 24,
  parameter int unsigned COEF = 1
) (
  input  logic [IW-1:0] in_i,
  output logic [OW-1:0] prod_o
);

  localparam logic [OW-1:0] K = OW'(COEF);

  generate
    if (COEF == 0) begin : g_zero
      assign prod_o = '0;
    end else if (COEF == 1) begin : g_pass
      assign prod_o = OW'(in_i);
    end else begin : g_mul
      assign prod_o = OW'(in_i) * K;
    end
  endgenerate

endmodule

// File: rtl/poly_accum.sv
module poly_accum #(
  parameter int OW = 24,
  localparam int SW = OW + 2
) (
  input  logic          en_i,
  input  logic [OW-1:0] t0_i,
  input  logic [OW-1:0] t1_i,
  input  logic [OW-1:0] t2_i,
  output logic [OW-1:0] sum_o
);

  logic [SW-1:0] wide_sum;

  always_comb begin
    wide_sum = SW'(t0_i) + SW'(t1_i) + SW'(t2_i);
  end

  always_comb begin
    sum_o = en_i ? wide_sum[OW-1:0] : '0;
  end

  // R3: the guard bits above the result port never carry a value
  always_comb begin
    assert_no_overflow_R3: assert (wide_sum[SW-1:OW] == '0);
  end

endmodule

// File: rtl/quad_poly_eval.sv
module quad_poly_eval
  import poly_pkg::*;
#(
  parameter int C0 = 7,
  parameter int C1 = 13,
  parameter int C2 = 3,
  parameter int XW = 8,
  parameter int CW = 8,
  localparam int RW = result_width(XW, CW)
) (
  input  logic          enable,
  input  logic [XW-1:0] x_in,
  output logic [RW-1:0] y_out
);

  localparam int SQW  = 2 * XW;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic [RW-1:0]  K0     = RW'(C0);
  localparam logic [SQW-1:0] SQ_MAX = SQW'(((1 << XW) - 1) * ((1 << XW) - 1));

  generate
    if (C0 < 0 || C0 > CMAX || C1 < 0 || C1 > CMAX || C2 < 0 || C2 > CMAX) begin : g_bad_coef
      $error("quad_poly_eval: coefficient outside 0..%0d", CMAX);
    end
  endgenerate

  logic [SQW-1:0] sq;
  logic [RW-1:0]  term0;
  logic [RW-1:0]  term1;
  logic [RW-1:0]  term2;

  poly_square #(.XW(XW)) u_square (
    .op_i (x_in),
    .sq_o (sq)
  );

  poly_scale #(.IW(XW), .OW(RW), .COEF(C1)) u_lin (
    .in_i   (x_in),
    .prod_o (term1)
  );

  poly_scale #(.IW(SQW), .OW(RW), .COEF(C2)) u_quad (
    .in_i   (sq),
    .prod_o (term2)
  );

  assign term0 = K0;

  poly_accum #(.OW(RW)) u_accum (
    .en_i  (enable),
    .t0_i  (term0),
    .t1_i  (term1),
    .t2_i  (term2),
    .sum_o (y_out)
  );

  always_comb begin
    if (!enable) begin
      assert_gate_zero_R2: assert (y_out == '0);
    end
    if (enable && x_in == '0) begin
      assert_const_term_R5: assert (y_out == K0);
    end
    if (enable) begin
      assert_lower_bound_R1: assert (y_out >= K0);
    end
    assert_square_bound_R1: assert (sq <= SQ_MAX);
  end

endmodule

// File: tb/test_quad_poly_eval.sv
`timescale 1ns/1ps
module test_quad_poly_eval;

  localparam int XW = 8;
  localparam int RW = poly_pkg::result_width(8, 8);

  localparam int A0 = 7,   A1 = 13,  A2 = 3;
  localparam int B0 = 255, B1 = 255, B2 = 255;
  localparam int D0 = 200, D1 = 0,   D2 = 1;

  logic clk;
  logic rst_n;
  logic enable;
  logic [XW-1:0] x_in;
  logic [RW-1:0] y_a, y_b, y_d;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int     x;
    bit     en;
    longint ea;
    longint eb;
    longint ed;
  } item_t;

  item_t sb[$];

  quad_poly_eval #(.C0(A0), .C1(A1), .C2(A2)) i_quad_poly_eval (
    .enable(enable), .x_in(x_in), .y_out(y_a));
  quad_poly_eval #(.C0(B0), .C1(B1), .C2(B2)) i_quad_poly_eval_max (
    .enable(enable), .x_in(x_in), .y_out(y_b));
  quad_poly_eval #(.C0(D0), .C1(D1), .C2(D2)) i_quad_poly_eval_nolin (
    .enable(enable), .x_in(x_in), .y_out(y_d));

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic longint model(int c0, int c1, int c2, int x, bit en);
    longint lx;
    lx = longint'(x);
    return en ? (longint'(c0) + longint'(c1) * lx + longint'(c2) * lx * lx) : 64'sd0;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int x, bit en);
    item_t it;
    @(posedge clk);
    #1;
    x_in   = XW'(x);
    enable = en;
    it.x  = x;
    it.en = en;
    it.ea = model(A0, A1, A2, x, en);
    it.eb = model(B0, B1, B2, x, en);
    it.ed = model(D0, D1, D2, x, en);
    sb.push_back(it);
  endtask

  // Monitor: compare at the falling edge, half a period after the drive
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.en ? (it.x == 0 ? "R5" : "R1") : "R2", longint'(y_a), it.ea);
        check(it.en ? "R3" : "R2", longint'(y_b), it.eb);
        check(it.en ? "R6" : "R2", longint'(y_d), it.ed);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n  = 0;
    enable = 0;
    x_in   = '0;
    repeat (3) @(posedge clk);
    #2;
    // reset state: enable low forces zero (R2)
    check("R2", longint'(y_a), 0);
    rst_n = 1;

    for (int x = 0; x < 256; x++) drive(x, 1'b1);
    for (int x = 255; x >= 0; x--) drive(x, 1'b0);
    drive(255, 1'b1);   // R3 corner on the all-255 set
    drive(0, 1'b1);     // R5 constant term alone
    drive(128, 1'b0);

    while (sb.size() > 0) @(negedge clk);

    // R4: two operand changes inside one half period, no clock edge
    @(posedge clk);
    #1;
    enable = 1;
    x_in = 8'd3;
    #1;
    check("R4", longint'(y_a), model(A0, A1, A2, 3, 1'b1));
    x_in = 8'd200;
    #1;
    check("R4", longint'(y_a), model(A0, A1, A2, 200, 1'b1));
    enable = 0;
    #0.5;
    check("R4", longint'(y_a), 0);
    check("R3", longint'(RW), 24);

    finish_run();
  end

endmodule